// File: doc/BRIEF.md
# Luma Level and RGB Gain Adjuster

This block scales the three components of a 4:4:4 pixel stream under register control. A mode input picks how each pixel is treated. In YCbCr mode the luminance sample is multiplied by one of sixteen levels, chosen by a 4-bit code. The levels run from 78.125 % to 125 % in equal steps of 3.125 %. The two chroma samples pass through unchanged. In RGB mode each of the green, blue and red samples gets its own gain, set by an 8-bit code, from zero up to twice the input.

Each product is rounded to the nearest integer and clamped to the top of the 10-bit range. The result appears two clock cycles after the pixel is accepted, together with a valid strobe. The mode and all codes are sampled on the same edge as the pixel they apply to, so they may change from one pixel to the next. On cycles with no valid output, the outputs keep the last result.

Top module: `luma_gain_adj`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_c0, out_c1 and out_c2 are 0.
- R2: out_valid equals the in_valid value from two rising edges earlier, and the data that goes with it appears in the same cycle.
- R3: With in_rgb_mode = 0 and luma code c (0 to 15), out_c0 = min(1023, floor((Y*(25+c) + 16) / 32)), where Y is in_c0. Code 0 gives 78.125 % and code 15 gives 125 %.
- R4: With in_rgb_mode = 0, out_c1 and out_c2 equal in_c1 and in_c2 exactly.
- R5: With in_rgb_mode = 1, each lane gives min(1023, floor((X*G + 64) / 128)). X is the input sample. G is the gain code N when N < 255, and 256 when N = 255. Lane c0 (green) uses gain_g, lane c1 (blue) uses gain_b and lane c2 (red) uses gain_r.
- R6: In RGB mode, gain code 128 returns the input unchanged and gain code 0 gives 0.
- R7: Any rounded result above 1023 is output as 1023. For example, gain code 255 with an input of 512 or more gives 1023.
- R8: In RGB mode luma_code has no effect. In YCbCr mode gain_r, gain_g and gain_b have no effect.
- R9: The mode and codes are taken with each pixel, so back-to-back pixels may use different settings. While out_valid is 0, the three outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel strobe |
| in_rgb_mode | input | 1 | 1: RGB gains, 0: YCbCr luma level |
| in_c0 | input | 10 | Y or G sample |
| in_c1 | input | 10 | Cb or B sample |
| in_c2 | input | 10 | Cr or R sample |
| luma_code | input | 4 | Luma level code |
| gain_r | input | 8 | Red gain code |
| gain_g | input | 8 | Green gain code |
| gain_b | input | 8 | Blue gain code |
| out_valid | output | 1 | Result strobe |
| out_c0 | output | 10 | Adjusted Y or G |
| out_c1 | output | 10 | Cb or adjusted B |
| out_c2 | output | 10 | Cr or adjusted R |

## Verification
Every result falls due on the second rising edge after the pixel is taken, so the single-pixel sweeps drive on a falling edge and compare two falling edges later. On the falling edge in between they confirm that out_valid is still low. A streaming run feeds a gapped valid pattern with settings that change on every pixel. On each falling edge it compares the outputs with the expectation recorded two drives earlier, and with the last held value on gap cycles. The checker compares outputs with the inputs from two edges back only once two edges have passed since reset.

// File: rtl/luma_gain_adj.sv
module luma_gain_adj #(
  parameter int DW        = 10,
  parameter int LW        = 4,
  parameter int GW        = 8,
  parameter int LUMA_BASE = 25,
  parameter int LUMA_FRAC = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_rgb_mode,
  input  logic [DW-1:0] in_c0,
  input  logic [DW-1:0] in_c1,
  input  logic [DW-1:0] in_c2,
  input  logic [LW-1:0] luma_code,
  input  logic [GW-1:0] gain_r,
  input  logic [GW-1:0] gain_g,
  input  logic [GW-1:0] gain_b,
  output logic          out_valid,
  output logic [DW-1:0] out_c0,
  output logic [DW-1:0] out_c1,
  output logic [DW-1:0] out_c2
);
  localparam int FRAC  = GW - 1;
  localparam int UNITY = 1 << FRAC;
  localparam int MW    = GW + 1;
  localparam int PW    = DW + MW;
  localparam int HALF  = 1 << (FRAC - 1);

  function automatic logic [MW-1:0] gain_eff(input logic [GW-1:0] code);
    return (&code) ? MW'(2 * UNITY) : {1'b0, code};
  endfunction

  logic [MW-1:0] luma_mul;
  logic [DW-1:0] pix_in  [3];
  logic [MW-1:0] mul     [3];
  logic [PW-1:0] prod_q  [3];
  logic [DW-1:0] res_q   [3];
  logic          v1_q;

  assign luma_mul  = MW'((LUMA_BASE + int'(luma_code)) << (FRAC - LUMA_FRAC));
  assign pix_in[0] = in_c0;
  assign pix_in[1] = in_c1;
  assign pix_in[2] = in_c2;
  assign mul[0]    = in_rgb_mode ? gain_eff(gain_g) : luma_mul;
  assign mul[1]    = in_rgb_mode ? gain_eff(gain_b) : MW'(UNITY);
  assign mul[2]    = in_rgb_mode ? gain_eff(gain_r) : MW'(UNITY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1_q      <= in_valid;
      out_valid <= v1_q;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_lane
    logic [PW:0]      rsum;
    logic [PW-FRAC:0] rnd;
    logic [DW-1:0]    sat;

    assign rsum = {1'b0, prod_q[i]} + (PW+1)'(HALF);
    assign rnd  = rsum[PW:FRAC];
    assign sat  = (|rnd[PW-FRAC:DW]) ? {DW{1'b1}} : rnd[DW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q[i] <= '0;
        res_q[i]  <= '0;
      end else begin
        if (in_valid) prod_q[i] <= pix_in[i] * mul[i];
        if (v1_q)     res_q[i]  <= sat;
      end
    end
  end

  assign out_c0 = res_q[0];
  assign out_c1 = res_q[1];
  assign out_c2 = res_q[2];
endmodule

module luma_gain_adj_chk #(
  parameter int DW = 10,
  parameter int LW = 4,
  parameter int GW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_rgb_mode,
  input logic [DW-1:0] in_c0,
  input logic [DW-1:0] in_c1,
  input logic [DW-1:0] in_c2,
  input logic [LW-1:0] luma_code,
  input logic [GW-1:0] gain_r,
  input logic [GW-1:0] gain_g,
  input logic [GW-1:0] gain_b,
  input logic          out_valid,
  input logic [DW-1:0] out_c0,
  input logic [DW-1:0] out_c1,
  input logic [DW-1:0] out_c2
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_c0) && $stable(out_c1) && $stable(out_c2))); // R9

  AST_CHROMA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(in_valid, 2) && !$past(in_rgb_mode, 2))
      |-> (out_c1 == $past(in_c1, 2) && out_c2 == $past(in_c2, 2))); // R4

  AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(in_valid, 2) && $past(in_rgb_mode, 2) && $past(gain_g, 2) == GW'(1 << (GW-1)))
      |-> (out_c0 == $past(in_c0, 2))); // R6

  AST_LUMA_BELOW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(in_valid, 2) && !$past(in_rgb_mode, 2) && $past(luma_code, 2) < LW'(7))
      |-> (out_c0 <= $past(in_c0, 2))); // R3

  AST_FULL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(in_valid, 2) && $past(in_rgb_mode, 2) && (&$past(gain_r, 2)) && $past(in_c2[DW-1], 2))
      |-> (out_c2 == {DW{1'b1}})); // R7
endmodule

bind luma_gain_adj luma_gain_adj_chk #(.DW(DW), .LW(LW), .GW(GW)) u_chk (.*);

// File: tb/sim_luma_gain_adj.sv
module sim_luma_gain_adj;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_rgb_mode = 1'b0;
  logic [9:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic [3:0] luma_code = '0;
  logic [7:0] gain_r = '0, gain_g = '0, gain_b = '0;
  logic       out_valid;
  logic [9:0] out_c0, out_c1, out_c2;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  luma_gain_adj u0 (.*);

  function automatic int sat10(input int v);
    return (v > 1023) ? 1023 : v;
  endfunction
  function automatic int exp_luma(input int y, input int c);
    return sat10((y * (25 + c) + 16) / 32);
  endfunction
  function automatic int exp_gain(input int x, input int n);
    int g;
    g = (n == 255) ? 256 : n;
    return sat10((x * g + 64) / 128);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic one_pixel(input bit rgb, input int a, input int b, input int c,
                           input int lc, input int gr, input int gg, input int gb,
                           input string r0, input string r12);
    int e0, e1, e2;
    if (rgb) begin
      e0 = exp_gain(a, gg); e1 = exp_gain(b, gb); e2 = exp_gain(c, gr);
    end else begin
      e0 = exp_luma(a, lc); e1 = b; e2 = c;
    end
    @(negedge clk);
    in_valid = 1'b1; in_rgb_mode = rgb;
    in_c0 = 10'(a); in_c1 = 10'(b); in_c2 = 10'(c);
    luma_code = 4'(lc); gain_r = 8'(gr); gain_g = 8'(gg); gain_b = 8'(gb);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 early", int'(out_valid), 0);
    @(negedge clk);
    chk("R2", int'(out_valid), 1);
    chk(r0, int'(out_c0), e0);
    chk(r12, int'(out_c1), e1);
    chk(r12, int'(out_c2), e2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int xs[6] = '{0, 1, 300, 511, 512, 1023};
    bit vp[12] = '{1, 1, 0, 1, 1, 1, 0, 0, 1, 0, 0, 0};
    int e0q[12], e1q[12], e2q[12];
    int h0, h1, h2;

    // R1: reset state with activity on the inputs
    in_valid = 1'b1; in_c0 = 10'd999; in_rgb_mode = 1'b1; gain_g = 8'd200;
    repeat (3) @(negedge clk);
    chk("R1", int'(out_valid), 0);
    chk("R1", int'(out_c0), 0);
    chk("R1", int'(out_c1), 0);
    chk("R1", int'(out_c2), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R3, R4, R8: luma sweep with arbitrary gains that must not matter
    for (int lc = 0; lc < 16; lc++) begin
      for (int y = 0; y < 1024; y += 33)
        one_pixel(1'b0, y, 1023 - y, (y * 7) % 1024, lc, lc * 17, 255 - lc, lc * 5,
                  "R3/R8 luma", "R4 chroma");
      one_pixel(1'b0, 1023, 0, 1023, lc, 1, 2, 3, "R3/R7 luma", "R4 chroma");
    end

    // R5, R6, R7, R8: gain sweep with arbitrary luma codes
    for (int n = 0; n < 256; n++)
      for (int k = 0; k < 6; k++)
        one_pixel(1'b1, xs[k], xs[5-k], xs[(k+2)%6], n % 16, n, 255 - n, (n * 37) % 256,
                  "R5/R8 green", "R5/R7 blue-red");
    one_pixel(1'b1, 777, 555, 333, 0, 128, 128, 128, "R6 unity", "R6 unity");
    one_pixel(1'b1, 777, 555, 333, 0, 0, 0, 0, "R6 zero", "R6 zero");
    one_pixel(1'b1, 512, 600, 1023, 9, 255, 255, 255, "R7 sat", "R7 sat");

    // R2, R9: streaming, settings change per pixel, gaps hold
    h0 = out_c0; h1 = out_c1; h2 = out_c2;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R2 stream", int'(out_valid), int'(vp[i-2]));
        if (vp[i-2]) begin h0 = e0q[i-2]; h1 = e1q[i-2]; h2 = e2q[i-2]; end
        chk("R9 stream", int'(out_c0), h0);
        chk("R9 stream", int'(out_c1), h1);
        chk("R9 stream", int'(out_c2), h2);
      end
      in_valid = vp[i];
      in_rgb_mode = i[0];
      in_c0 = 10'(100 + i * 70); in_c1 = 10'(900 - i * 40); in_c2 = 10'(i * 85);
      luma_code = 4'(i); gain_r = 8'(i * 20); gain_g = 8'(250 - i); gain_b = 8'(64 + i);
      if (i[0]) begin
        e0q[i] = exp_gain(100 + i * 70, 250 - i);
        e1q[i] = exp_gain(900 - i * 40, 64 + i);
        e2q[i] = exp_gain(i * 85, i * 20);
      end else begin
        e0q[i] = exp_luma(100 + i * 70, i);
        e1q[i] = 900 - i * 40;
        e2q[i] = i * 85;
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule